// File: doc/BRIEF.md
# Extended Configuration Switch Executor

This block is card-side logic that carries out a switch command against a 512-byte extended configuration array. A single 32-bit argument, qualified by a one-cycle valid strobe, selects one of four access modes. Three of the modes change one byte of the array with a read-modify-write: set the bits given in a value byte, clear them, or overwrite the whole byte. The fourth mode leaves the array alone and loads a small one-hot command-set register instead.

Every command, accepted or rejected, is acknowledged by a one-cycle done pulse. A command whose reserved argument bits are not zero, that targets a byte marked read-only in a per-byte writable mask, or that asks for a command set that is not one-hot changes nothing. Such a command sets a sticky error flag, which the host clears with a status-read strobe. A combinational byte-read port lets the host side inspect any of the 512 bytes. Only the lower 256 bytes can be targeted, because the index field in the argument is 8 bits wide.

Top module: `xcfg_switch_unit`

## Requirements
- R1: The argument is decoded as mode = bits [25:24], byte index = bits [23:16], value byte = bits [15:8], command set = bits [2:0]. In the three byte modes the command-set bits have no effect.
- R2: Mode 1 replaces the addressed byte with (old OR value).
- R3: Mode 2 replaces the addressed byte with (old AND NOT value).
- R4: Mode 3 replaces the addressed byte with the value byte.
- R5: Mode 0 loads the command-set register from bits [2:0] when that field has exactly one bit set (001 normal, 010 secure, 100 content-protection secure). The array is not changed. Any other field value sets the error flag and leaves the register as it was.
- R6: A nonzero bit in [31:26] or [7:3] leaves both the array and the command-set register unchanged and sets the error flag.
- R7: A byte-mode command whose index is read-only in the writable mask leaves that byte unchanged and sets the error flag. With the default mask, bytes 0 to 191 are writable and all other bytes are read-only.
- R8: `sw_done` is high for exactly the one cycle after each cycle in which `cmd_valid` is high, for accepted and rejected commands alike. The update can be seen on `rd_data` in that same cycle.
- R9: The error flag stays high until a cycle with `stat_rd` high and no failing command. If a failing command and `stat_rd` arrive in the same cycle, the flag stays set.
- R10: `rd_data` shows byte `rd_addr` (0 to 511) combinationally. Bytes 256 to 511 are never changed by any command.
- R11: After reset, byte i holds (3*i + 1) mod 256, the command set is 001, and `sw_err` and `sw_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Argument valid strobe |
| cmd_arg | input | 32 | Switch command argument |
| stat_rd | input | 1 | Status read strobe; clears the error flag |
| rd_addr | input | 9 | Byte address for the host read port |
| rd_data | output | 8 | Byte at rd_addr |
| sw_done | output | 1 | One-cycle completion pulse |
| sw_err | output | 1 | Sticky switch-error flag |
| active_cset | output | 3 | Current one-hot command set |

## Verification
The bench goes after the writable boundary at bytes 191 and 192. A mask that is off by one there would either let byte 192 be modified or reject byte 191. It also writes byte 0 and then reads byte 256, which exposes an index that is extended into the upper half of the array. Reserved bits set at both ends of the argument, and command-set fields of 000 and 011, check that a rejected command does not partly update state. A failing command arriving together with a status read checks the priority of set over clear; a design with the priority reversed would lose the error. Back-to-back commands on the same byte check that each read-modify-write sees the result of the one before it and that done stays high for exactly two cycles.

// File: rtl/xsw_pkg.sv
package xsw_pkg;
  localparam int CFG_BYTES = 512;
  localparam int BYTE_W    = 8;
  localparam int IDX_W     = 8;
  localparam int CSET_W    = 3;
  localparam int ARG_W     = 32;
  localparam int WR_LIMIT  = 192;
  localparam int ADDR_W    = $clog2(CFG_BYTES);

  typedef enum logic [1:0] {
    AM_CSET = 2'd0,
    AM_SETB = 2'd1,
    AM_CLRB = 2'd2,
    AM_PUT  = 2'd3
  } acc_mode_e;

  typedef struct packed {
    acc_mode_e           mode;
    logic [IDX_W-1:0]    idx;
    logic [BYTE_W-1:0]   val;
    logic [CSET_W-1:0]   cset;
  } sw_req_t;

  localparam logic [CSET_W-1:0] CSET_NORMAL = 3'b001;

  // Power-up content of byte i.
  function automatic logic [BYTE_W-1:0] reset_byte(input int unsigned i);
    return BYTE_W'(i * 3 + 1);
  endfunction

  // Default writable mask: the low WR_LIMIT bytes.
  function automatic logic [CFG_BYTES-1:0] default_wr_mask();
    logic [CFG_BYTES-1:0] m;
    for (int i = 0; i < CFG_BYTES; i++) m[i] = (i < WR_LIMIT);
    return m;
  endfunction

  // Byte update rule chosen by the access mode.
  function automatic logic [BYTE_W-1:0] merge_byte(input acc_mode_e mode,
                                                   input logic [BYTE_W-1:0] old_b,
                                                   input logic [BYTE_W-1:0] val_b);
    case (mode)
      AM_SETB: return old_b | val_b;
      AM_CLRB: return old_b & ~val_b;
      AM_PUT:  return val_b;
      default: return old_b;
    endcase
  endfunction

  function automatic logic cset_legal(input logic [CSET_W-1:0] c);
    return $countones(c) == 1;
  endfunction
endpackage

// File: rtl/xsw_arg_decode.sv
module xsw_arg_decode
  import xsw_pkg::*;
(
  input  logic [ARG_W-1:0] arg,
  output sw_req_t          req,
  output logic             rsvd_bad
);
  localparam int MODE_LO = 24;
  localparam int IDX_LO  = 16;
  localparam int VAL_LO  = 8;
  localparam int HI_RSV  = MODE_LO + 2;
  localparam int LO_RSV  = CSET_W;

  always_comb begin
    req.mode = acc_mode_e'(arg[MODE_LO +: 2]);
    req.idx  = arg[IDX_LO +: IDX_W];
    req.val  = arg[VAL_LO +: BYTE_W];
    req.cset = arg[0 +: CSET_W];
    rsvd_bad = (|arg[ARG_W-1:HI_RSV]) | (|arg[VAL_LO-1:LO_RSV]);
  end
endmodule

// File: rtl/xsw_byte_merge.sv
module xsw_byte_merge
  import xsw_pkg::*;
(
  input  acc_mode_e         mode,
  input  logic [BYTE_W-1:0] old_b,
  input  logic [BYTE_W-1:0] val_b,
  output logic [BYTE_W-1:0] new_b
);
  assign new_b = merge_byte(mode, old_b, val_b);
endmodule

// File: rtl/xsw_byte_store.sv
module xsw_byte_store
  import xsw_pkg::*;
#(
  parameter int DEPTH = CFG_BYTES,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  output logic [BYTE_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [BYTE_W-1:0] rdata_b
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= reset_byte(i);
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/xcfg_switch_unit.sv
module xcfg_switch_unit
  import xsw_pkg::*;
#(
  parameter logic [CFG_BYTES-1:0] WR_MASK = default_wr_mask()
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [ARG_W-1:0]     cmd_arg,
  input  logic                 stat_rd,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [BYTE_W-1:0]    rd_data,
  output logic                 sw_done,
  output logic                 sw_err,
  output logic [CSET_W-1:0]    active_cset
);
  localparam int PAD_W = ADDR_W - IDX_W;

  sw_req_t           req;
  logic              fault_fmt;
  logic              fault_cset;
  logic              fault_ro;
  logic              fault_any;
  logic              is_cset;
  logic              wr_fire;
  logic              cset_fire;
  logic              err_set;
  logic [ADDR_W-1:0] tgt_addr;
  logic [BYTE_W-1:0] old_b;
  logic [BYTE_W-1:0] new_b;
  logic              done_q;
  logic              err_q;
  logic [CSET_W-1:0] cset_q;

  xsw_arg_decode u_dec (
    .arg      (cmd_arg),
    .req      (req),
    .rsvd_bad (fault_fmt)
  );

  assign tgt_addr   = {{PAD_W{1'b0}}, req.idx};
  assign is_cset    = (req.mode == AM_CSET);
  assign fault_cset = is_cset && !fault_fmt && !cset_legal(req.cset);
  assign fault_ro   = !is_cset && !fault_fmt && !WR_MASK[tgt_addr];
  assign fault_any  = fault_fmt | fault_cset | fault_ro;
  assign wr_fire    = cmd_valid && !is_cset && !fault_any;
  assign cset_fire  = cmd_valid && is_cset && !fault_any;
  assign err_set    = cmd_valid && fault_any;

  xsw_byte_merge u_merge (
    .mode  (req.mode),
    .old_b (old_b),
    .val_b (req.val),
    .new_b (new_b)
  );

  xsw_byte_store #(.DEPTH(CFG_BYTES), .AW(ADDR_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_fire),
    .waddr   (tgt_addr),
    .wdata   (new_b),
    .raddr_a (rd_addr),
    .rdata_a (rd_data),
    .raddr_b (tgt_addr),
    .rdata_b (old_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      cset_q <= CSET_NORMAL;
    end else begin
      done_q <= cmd_valid;
      if (err_set)      err_q <= 1'b1;
      else if (stat_rd) err_q <= 1'b0;
      if (cset_fire)    cset_q <= req.cset;
    end
  end

  assign sw_done     = done_q;
  assign sw_err      = err_q;
  assign active_cset = cset_q;
endmodule

// File: rtl/xsw_switch_chk.sv
module xsw_switch_chk
  import xsw_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              stat_rd,
  input logic              sw_done,
  input logic              sw_err,
  input logic [CSET_W-1:0] active_cset,
  input logic              fault_any,
  input logic              fault_fmt,
  input logic              cset_fire
);
  // R8
  done_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> sw_done);

  // R8
  done_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    sw_done |-> $past(cmd_valid));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_err && !stat_rd) |=> sw_err);

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !(cmd_valid && fault_any)) |=> !sw_err);

  // R7
  fault_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && fault_any) |=> sw_err);

  // R6
  rsvd_keeps_cset_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && fault_fmt) |=> $stable(active_cset));

  // R5
  cset_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(active_cset) == 1);

  // R5
  cset_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cset_fire |=> $stable(active_cset));
endmodule

bind xcfg_switch_unit xsw_switch_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .stat_rd     (stat_rd),
  .sw_done     (sw_done),
  .sw_err      (sw_err),
  .active_cset (active_cset),
  .fault_any   (fault_any),
  .fault_fmt   (fault_fmt),
  .cset_fire   (cset_fire)
);

// File: tb/xcfg_switch_unit_tb.sv
`timescale 1ns/1ps
module xcfg_switch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_arg = 32'd0;
  logic        stat_rd = 1'b0;
  logic [8:0]  rd_addr = 9'd0;
  logic [7:0]  rd_data;
  logic        sw_done;
  logic        sw_err;
  logic [2:0]  active_cset;

  always #10 clk = ~clk;

  xcfg_switch_unit dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_arg(cmd_arg),
    .stat_rd(stat_rd), .rd_addr(rd_addr), .rd_data(rd_data),
    .sw_done(sw_done), .sw_err(sw_err), .active_cset(active_cset)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 0;
  string cur_tag = "R11";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  int  ref_mem [512];
  int  ref_cset, ref_err, ref_done;
  always @(posedge clk) begin
    if (rst) begin
      foreach (ref_mem[i]) ref_mem[i] = (3 * i + 1) % 256;
      ref_cset = 1; ref_err = 0; ref_done = 0;
    end else begin
      bit rej;
      int md, ix, vb, cs;
      rej = 0;
      ref_done = cmd_valid;
      if (cmd_valid) begin
        md = int'(cmd_arg[25:24]);
        ix = int'(cmd_arg[23:16]);
        vb = int'(cmd_arg[15:8]);
        cs = int'(cmd_arg[2:0]);
        if ((cmd_arg >> 26) != 0 || cmd_arg[7:3] != 0) rej = 1;
        else if (md == 0) begin
          if (cs == 1 || cs == 2 || cs == 4) ref_cset = cs;
          else rej = 1;
        end else if (ix < 192) begin
          if (md == 1)      ref_mem[ix] = ref_mem[ix] | vb;
          else if (md == 2) ref_mem[ix] = ref_mem[ix] & (255 - vb);
          else              ref_mem[ix] = vb;
        end else rej = 1;
      end
      if (rej) ref_err = 1;
      else if (stat_rd) ref_err = 0;
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(sw_done == ref_done[0], "R8 done", int'(sw_done), ref_done);
      chk(sw_err == ref_err[0], "R9 err", int'(sw_err), ref_err);
      chk(int'(active_cset) == ref_cset, "R5 cset", int'(active_cset), ref_cset);
      chk(int'(rd_data) == ref_mem[rd_addr], cur_tag, int'(rd_data), ref_mem[rd_addr]);
    end
  end

  task automatic issue(input logic [31:0] a, input bit rd = 0);
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_arg = a; stat_rd = rd;
    @(posedge clk); #2;
    cmd_valid = 1'b0; cmd_arg = 32'd0; stat_rd = 1'b0;
  endtask

  task automatic peek(input int a, input int exp, input string tag);
    rd_addr = 9'(a);
    @(negedge clk);
    chk(int'(rd_data) == exp, tag, int'(rd_data), exp);
  endtask

  task automatic clear_status();
    @(posedge clk); #2; stat_rd = 1'b1;
    @(posedge clk); #2; stat_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(sw_done == 1'b0, "R11 done", int'(sw_done), 0);
    chk(sw_err == 1'b0, "R11 err", int'(sw_err), 0);
    chk(active_cset == 3'b001, "R11 cset", int'(active_cset), 1);
    peek(0, 1, "R11 byte0");
    peek(200, 89, "R11 byte200");
    peek(300, 133, "R11 byte300");
    peek(511, 254, "R11 byte511");

    cur_tag = "R2";
    issue(32'h010A_F000); peek(10, 8'hFF, "R2 or");
    cur_tag = "R3";
    issue(32'h020A_0F00); peek(10, 8'hF0, "R3 andnot");
    cur_tag = "R4";
    issue(32'h03BF_3C00); peek(191, 8'h3C, "R4 put edge");
    chk(sw_err == 1'b0, "R7 byte191 writable", int'(sw_err), 0);

    cur_tag = "R7";
    issue(32'h03C0_0000); peek(192, 65, "R7 readonly kept");
    chk(sw_err == 1'b1, "R7 err", int'(sw_err), 1);
    clear_status();
    @(negedge clk);
    chk(sw_err == 1'b0, "R9 cleared", int'(sw_err), 0);

    cur_tag = "R6";
    issue(32'h8305_AA00); peek(5, 16, "R6 high rsvd");
    chk(sw_err == 1'b1, "R6 err", int'(sw_err), 1);
    clear_status();
    issue(32'h0305_AA08); peek(5, 16, "R6 low rsvd");
    chk(sw_err == 1'b1, "R6 err low", int'(sw_err), 1);

    cur_tag = "R9";
    issue(32'h0305_AA10, 1'b1);
    @(negedge clk);
    chk(sw_err == 1'b1, "R9 set wins", int'(sw_err), 1);
    clear_status();

    cur_tag = "R5";
    issue(32'h0007_5502); peek(7, 22, "R5 array untouched");
    chk(active_cset == 3'b010, "R5 secure", int'(active_cset), 2);
    issue(32'h0000_0003); @(negedge clk);
    chk(active_cset == 3'b010, "R5 reject 011", int'(active_cset), 2);
    chk(sw_err == 1'b1, "R5 err 011", int'(sw_err), 1);
    clear_status();
    issue(32'h0000_0000); @(negedge clk);
    chk(sw_err == 1'b1, "R5 err 000", int'(sw_err), 1);
    clear_status();
    issue(32'h0000_0004); @(negedge clk);
    chk(active_cset == 3'b100, "R5 cp secure", int'(active_cset), 4);

    cur_tag = "R1";
    issue(32'h0314_6607); peek(20, 8'h66, "R1 cset bits ignored");

    cur_tag = "R10";
    issue(32'h0300_9900); peek(0, 8'h99, "R10 low byte");
    peek(256, 1, "R10 upper untouched");

    cur_tag = "R8";
    rd_addr = 9'd30;
    @(posedge clk); #2; cmd_valid = 1'b1; cmd_arg = 32'h011E_8000;
    @(posedge clk); #2; cmd_arg = 32'h021E_0100;
    @(negedge clk);
    chk(sw_done == 1'b1, "R8 first", int'(sw_done), 1);
    chk(rd_data == 8'hDB, "R8 first rmw", int'(rd_data), 8'hDB);
    @(posedge clk); #2; cmd_valid = 1'b0; cmd_arg = 32'd0;
    @(negedge clk);
    chk(sw_done == 1'b1, "R8 second", int'(sw_done), 1);
    chk(rd_data == 8'hDA, "R8 second rmw", int'(rd_data), 8'hDA);
    @(negedge clk);
    chk(sw_done == 1'b0, "R8 drop", int'(sw_done), 0);

    repeat (3) @(posedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule